// File: doc/BRIEF.md
# Eight-Input Interrupt Level Mapper

This block gathers eight level-sensitive device request lines and turns them into a 16-bit vector of processor interrupt levels. Each request line is tied to one fixed level by a sparse table; two of the lines map to level 0, which means "not connected", so they are ignored. A pending bit for each line follows its input. The mapped level bits are gated by a master enable.

A single byte-wide control register sits behind a minimal register port made of select, write strobe, write data and read data. There is no address, so every access reaches the same byte. Bit 6 of that byte cannot be set. Bit 0 is the master enable. The block also gives the number of the highest active level as a registered 4-bit code, for a processor or a downstream priority stage that wants one number and not a vector.

Top module: `irqmap_top`

## Requirements
- R1: While reset is high and after it is released, the control register reads 0x01, every pending bit is clear, `lvl_o` is 0 and `top_o` is 0.
- R2: At a clock edge where `sel_i` and `wr_i` are both high, the control register takes `wdata_i & 0xBF`. The new value shows on `rdata_o` straight after that edge, and bit 6 of `rdata_o` is always 0.
- R3: At an edge where `sel_i` or `wr_i` is low, the control register keeps its value, whatever `wdata_i` holds.
- R4: Each pending bit samples its request input on every clock edge. A level bit rises after the first edge at which a mapped input is seen high, and falls after the first edge at which no mapped input for that level is high.
- R5: Request bits map to levels as follows: bit 1 to level 1, bit 2 to level 4, bit 3 to level 6, bit 4 to level 8, bit 5 to level 10, and bit 7 to level 14. `lvl_o[k]` is high exactly when the register is enabled and some pending input maps to level k. Every other level bit stays 0.
- R6: Request bits 0 and 6 map to level 0 and are ignored. Driving them never sets any bit of `lvl_o`.
- R7: When control bit 0 is 0, `lvl_o` is all zero, but the pending bits keep tracking their inputs. After a write that sets bit 0 again, `lvl_o` shows the current pending state straight after that write edge.
- R8: `top_o` is the index of the highest set bit of `lvl_o` as it stood before the previous clock edge, or 0 when `lvl_o` was 0. It therefore trails `lvl_o` by one cycle.
- R9: A register write and a change of a request input at the same edge both take effect. The `lvl_o` that follows reflects both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Level-sensitive device request lines |
| sel_i | input | 1 | Register select |
| wr_i | input | 1 | Write strobe, effective together with sel_i |
| wdata_i | input | 8 | Write data for the control byte |
| rdata_o | output | 8 | Current control byte, returned for every access |
| lvl_o | output | 16 | Processor interrupt level vector |
| top_o | output | 4 | Registered number of the highest active level |

## Verification
The checker watches properties that hold on every cycle: bit 6 of the read data stays clear, level 0 and all unmapped level bits stay low, a cleared enable bit forces the vector to zero, the register holds without a qualified write, and `top_o` follows an idle or a level-14 vector one cycle later. The bench's scenarios cover what no single-cycle property captures. Each request line is walked alone against the mapping table, the pending state is kept while the block is disabled and shows again after re-enabling, priority is encoded across mixed requests, and a write and a request change land at the same edge.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;

    localparam int SRC_N  = 8;
    localparam int LVL_N  = 16;
    localparam int LVL_W  = $clog2(LVL_N);
    localparam int REG_W  = 8;
    localparam int EN_BIT = 0;

    localparam logic [REG_W-1:0] CTRL_RST  = 8'h01;
    localparam logic [REG_W-1:0] CTRL_KEEP = 8'hBF;

    typedef logic [REG_W-1:0] ctrl_t;
    typedef logic [SRC_N-1:0] src_vec_t;
    typedef logic [LVL_N-1:0] lvl_vec_t;

    typedef struct packed {
        logic        sel;
        logic        wr;
        ctrl_t       data;
    } reg_wr_t;

    // Fixed steering of request bit to processor level; 0 means unconnected.
    function automatic logic [LVL_W-1:0] src_level(input int idx);
        case (idx)
            1:       return LVL_W'(1);
            2:       return LVL_W'(4);
            3:       return LVL_W'(6);
            4:       return LVL_W'(8);
            5:       return LVL_W'(10);
            7:       return LVL_W'(14);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/irqmap_pending.sv
module irqmap_pending
    import irqmap_pkg::*;
#(
    parameter int N = SRC_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] pend_o
);

    logic [N-1:0] live_mask;
    logic [N-1:0] pend_q;

    // A line is live only if it is steered to a non-zero level.
    for (genvar s = 0; s < N; s++) begin : g_mask
        assign live_mask[s] = (src_level(s) != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= req_i & live_mask;
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/irqmap_ctrl.sv
module irqmap_ctrl
    import irqmap_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  reg_wr_t bus_i,
    output ctrl_t   ctrl_o
);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
        end else if (bus_i.sel && bus_i.wr) begin
            ctrl_q <= bus_i.data & CTRL_KEEP;
        end
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/irqmap_route.sv
module irqmap_route
    import irqmap_pkg::*;
#(
    parameter int NS = SRC_N,
    parameter int NL = LVL_N
) (
    input  logic [NS-1:0] pend_i,
    input  logic          enable_i,
    output logic [NL-1:0] lvl_o
);

    logic [NL-1:0][NS-1:0] hit;

    for (genvar l = 0; l < NL; l++) begin : g_lvl
        if (l == 0) begin : g_null
            // Level 0 is the "no interrupt" code and is never driven.
            assign hit[l]  = '0;
            assign lvl_o[l] = 1'b0;
        end else begin : g_real
            for (genvar s = 0; s < NS; s++) begin : g_src
                assign hit[l][s] = pend_i[s] && (src_level(s) == LVL_W'(l));
            end
            assign lvl_o[l] = enable_i && (|hit[l]);
        end
    end

endmodule

// File: rtl/irqmap_prio.sv
module irqmap_prio
    import irqmap_pkg::*;
#(
    parameter int NL = LVL_N,
    localparam int W = $clog2(NL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NL-1:0] lvl_i,
    output logic [W-1:0]  top_o
);

    logic [W-1:0] top_d;
    logic [W-1:0] top_q;

    always_comb begin
        top_d = '0;
        for (int i = 0; i < NL; i++) begin
            if (lvl_i[i]) begin
                top_d = W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign top_o = top_q;

endmodule

// File: rtl/irqmap_top.sv
module irqmap_top
    import irqmap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] req_i,
    input  logic             sel_i,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    output logic [LVL_N-1:0] lvl_o,
    output logic [LVL_W-1:0] top_o
);

    reg_wr_t  bus;
    ctrl_t    ctrl;
    src_vec_t pend;
    lvl_vec_t lvl;

    assign bus.sel  = sel_i;
    assign bus.wr   = wr_i;
    assign bus.data = wdata_i;

    irqmap_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .bus_i  (bus),
        .ctrl_o (ctrl)
    );

    irqmap_pending #(.N(SRC_N)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req_i),
        .pend_o (pend)
    );

    irqmap_route #(.NS(SRC_N), .NL(LVL_N)) u_route (
        .pend_i   (pend),
        .enable_i (ctrl[EN_BIT]),
        .lvl_o    (lvl)
    );

    irqmap_prio #(.NL(LVL_N)) u_prio (
        .clk   (clk),
        .rst   (rst),
        .lvl_i (lvl),
        .top_o (top_o)
    );

    assign rdata_o = ctrl;
    assign lvl_o   = lvl;

endmodule

// File: rtl/irqmap_chk.sv
module irqmap_chk
    import irqmap_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sel_i,
    input logic             wr_i,
    input logic [REG_W-1:0] rdata_o,
    input logic [LVL_N-1:0] lvl_o,
    input logic [LVL_W-1:0] top_o
);

    localparam logic [LVL_N-1:0] MAPPED = 16'b0100_0101_0101_0010;

    AST_BIT6_CLEAR: assert property (@(posedge clk) disable iff (rst) rdata_o[6] == 1'b0); // R2
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst) !(sel_i && wr_i) |=> $stable(rdata_o)); // R3
    AST_ONLY_MAPPED: assert property (@(posedge clk) disable iff (rst) (lvl_o & ~MAPPED) == '0); // R5
    AST_LEVEL0_LOW: assert property (@(posedge clk) disable iff (rst) lvl_o[0] == 1'b0); // R6
    AST_GATE_OFF: assert property (@(posedge clk) disable iff (rst) !rdata_o[EN_BIT] |-> lvl_o == '0); // R7
    AST_TOP_IDLE: assert property (@(posedge clk) disable iff (rst) lvl_o == '0 |=> top_o == '0); // R8
    AST_TOP_HIGH: assert property (@(posedge clk) disable iff (rst) lvl_o[14] |=> top_o == LVL_W'(14)); // R8

endmodule

bind irqmap_top irqmap_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .sel_i   (sel_i),
    .wr_i    (wr_i),
    .rdata_o (rdata_o),
    .lvl_o   (lvl_o),
    .top_o   (top_o)
);

// File: tb/tb_irqmap_top.sv
module tb_irqmap_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  req_i = '0;
    logic        sel_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [7:0]  wdata_i = '0;
    logic [7:0]  rdata_o;
    logic [15:0] lvl_o;
    logic [3:0]  top_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference state
    int m_ctrl = 1;
    int m_pend = 0;
    int m_top = 0;

    always #5 clk = ~clk;

    irqmap_top dut (
        .clk(clk), .rst(rst), .req_i(req_i), .sel_i(sel_i), .wr_i(wr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .lvl_o(lvl_o), .top_o(top_o)
    );

    function automatic int level_of(int b);
        int tbl[8] = '{0, 1, 4, 6, 8, 10, 0, 14};
        return tbl[b];
    endfunction

    function automatic int model_lvl();
        int v = 0;
        if ((m_ctrl & 1) == 0) return 0;
        for (int b = 0; b < 8; b++)
            if ((m_pend >> b) & 1) v |= (1 << level_of(b));
        return v;
    endfunction

    function automatic int highest(int v);
        int h = 0;
        for (int i = 0; i < 16; i++) if ((v >> i) & 1) h = i;
        return h;
    endfunction

    task automatic step(input string tag);
        int prev_lvl;
        @(posedge clk);
        prev_lvl = model_lvl();
        if (rst) begin
            m_ctrl = 1; m_pend = 0; m_top = 0;
        end else begin
            m_top = highest(prev_lvl);
            m_pend = 0;
            for (int b = 0; b < 8; b++)
                if (req_i[b] && level_of(b) != 0) m_pend |= (1 << b);
            if (sel_i && wr_i) m_ctrl = wdata_i & 8'hBF;
        end
        #2;
        total++;
        if (rdata_o !== 8'(m_ctrl) || lvl_o !== 16'(model_lvl()) || top_o !== 4'(m_top)) begin
            bad++;
            $display("FAIL %s: rdata=%h lvl=%h top=%0d expected rdata=%h lvl=%h top=%0d",
                     tag, rdata_o, lvl_o, top_o, 8'(m_ctrl), 16'(model_lvl()), m_top);
        end
    endtask

    task automatic wr(input logic [7:0] d, input logic s, input logic w, input string tag);
        sel_i = s; wr_i = w; wdata_i = d;
        step(tag);
        sel_i = 0; wr_i = 0;
        step(tag);
    endtask

    initial begin
        #3;
        step("R1"); step("R1");
        rst = 0;
        step("R1"); step("R1");

        // single-line walk against the mapping table
        for (int b = 0; b < 8; b++) begin
            req_i = 8'(1 << b);
            step((b == 0 || b == 6) ? "R6" : "R5");
            step("R8");
            req_i = '0;
            step("R4");
            step("R4");
        end

        // register writes and masking
        wr(8'hFF, 1, 1, "R2");
        wr(8'h40, 1, 1, "R2");
        wr(8'h00, 0, 1, "R3");
        wr(8'h00, 1, 0, "R3");
        wr(8'h81, 1, 1, "R2");

        // mixed requests and priority
        req_i = 8'hBE; step("R8"); step("R8");
        req_i = 8'h3E; step("R8"); step("R8");
        req_i = 8'h41; step("R6"); step("R6");

        // master enable gating with pending tracked underneath
        req_i = 8'h14;
        wr(8'h00, 1, 1, "R7");
        req_i = 8'h88; step("R7"); step("R7");
        wr(8'h01, 1, 1, "R7");
        step("R7");

        // write and request change at one edge
        sel_i = 1; wr_i = 1; wdata_i = 8'h00; req_i = 8'h02;
        step("R9");
        wdata_i = 8'h01; req_i = 8'h20;
        step("R9");
        sel_i = 0; wr_i = 0; req_i = 8'h00;
        step("R9"); step("R9");

        // reset in mid-operation
        req_i = 8'hFF; step("R4");
        rst = 1; step("R1");
        rst = 0; req_i = 8'h00; step("R1");

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule